// File: doc/BRIEF.md
# One-Time-Programmable Fuse Word Sequencer

The block sits between a register bus and a fuse array of 96 words of 32 bits. Software writes a configuration register to ask for array power and polls a status register until the power-good flag confirms it. It then writes a control register to start one operation on one word index. The operation is either a shadow load, which copies the array word into an on-chip shadow bank, or a program, which sets bits in the array word. A busy flag stays up for a fixed number of cycles while the operation runs. A failure flag reports a program the lock rules refused, or a command that was rejected.

Programming can only set bits. A program operation never touches the shadow copy, so software issues a shadow load afterwards to see the new value. Per-word program locks, per-word shadow-read locks and a global program lock are sticky registers: a bus write can set their bits, and only reset clears them. The fuse array is external. The block presents a word address, a read strobe with combinational read data, and a program strobe with the bits to set.

Top module: `fuse_seq`

Register map (word addresses on `bus_addr`): 0x00 configuration, where bit 0 requests array power. 0x01 control, a write-only register: bits 7:0 give the word index, and bit 8 selects program when 1 and shadow load when 0. 0x02 program data. 0x03 status, read-only: bit 3 busy, bit 4 failure, bit 5 power good. 0x04 global lock, where bit 4 blocks all programming. 0x08–0x0A program-lock banks and 0x0C–0x0E shadow-read-lock banks: bank b, bit j covers word 32·b+j. 0x80 + n is the read-only shadow of word n.

## Requirements
- R1: After reset, status, configuration, every lock register and every shadow word read 0.
- R2: Status bit 5 (power good) rises 8 cycles after configuration bit 0 is set and falls 8 cycles after it is cleared. It never changes while the request already matches it.
- R3: An accepted control write sets status bit 3 (busy) from the next cycle for exactly 16 cycles.
- R4: A shadow load (control bit 8 = 0) on an unlocked word copies the array word into shadow address 0x80 + index by the time busy clears.
- R5: A shadow load on a word whose shadow-read-lock bit is set writes 0 into that shadow word.
- R6: A program (control bit 8 = 1) ORs the program-data register into the array word, leaves the shadow word unchanged and clears status bit 4.
- R7: A program on a word whose program-lock bit is set leaves the array unchanged. It sets status bit 4 when the program data is non-zero.
- R8: While global lock bit 4 is set, every program leaves the array unchanged and sets status bit 4 when the program data is non-zero.
- R9: A control write while power good is 0 or while busy is ignored and sets status bit 4. An operation already running finishes normally.
- R10: A control write with an index above 95 is ignored: busy stays 0 and status bit 4 is set.
- R11: Lock registers are sticky: a write ORs into them, and writing 0 does not clear a set bit.
- R12: An accepted control write clears status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from bus_addr |
| arr_addr | output | 7 | Fuse array word index |
| arr_rd_en | output | 1 | Array read strobe, in the last busy cycle of an unlocked shadow load |
| arr_rdata | input | 32 | Array read data, combinational from arr_addr |
| arr_pgm_en | output | 1 | Array program strobe, in the last busy cycle of a permitted program |
| arr_pgm_bits | output | 32 | Bits to set in the addressed array word |

## Verification
The bench checks the busy window cycle by cycle. A counter that is off by one clears busy one cycle early or late, and the check fails. It reads the shadow after every program: a design that loads the shadow while programming returns the new value instead of the old one. It sets per-word, shadow-read and global locks and checks both the array contents and the shadow result, which catches a lock that decodes the wrong bank or bit. It also fires commands while unpowered, while busy, and with index 96. A design that accepts any of these starts busy or overwrites a shadow word, and the bench sees it.

// File: rtl/fuse_seq_pkg.sv
// Package: register offsets, bit positions and operation kind for the
// fuse word sequencer. Assumes word-addressed registers.
package fuse_seq_pkg;
    localparam int A_CFG    = 'h00;
    localparam int A_CMD    = 'h01;
    localparam int A_WDATA  = 'h02;
    localparam int A_STAT   = 'h03;
    localparam int A_GLOCK  = 'h04;
    localparam int A_PLOCK  = 'h08;
    localparam int A_RLOCK  = 'h0C;
    localparam int A_SHADOW = 'h80;

    localparam int CFG_PWR_BIT   = 0;
    localparam int ST_BUSY_BIT   = 3;
    localparam int ST_FAIL_BIT   = 4;
    localparam int ST_PWR_BIT    = 5;
    localparam int CMD_PGM_BIT   = 8;
    localparam int CMD_IDX_W     = 8;
    localparam int GLOCK_PGM_BIT = 4;

    typedef enum logic {
        OP_SHADOW_LOAD = 1'b0,
        OP_PROGRAM     = 1'b1
    } fuse_op_e;
endpackage

// File: rtl/fuse_pwr_ctrl.sv
// Power sequencer: power-good follows the request after PWR_DLY cycles of
// disagreement. It holds its state while an operation runs.
// Assumes PWR_DLY >= 2.
module fuse_pwr_ctrl #(
    parameter int PWR_DLY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_req,
    input  logic hold,
    output logic pwr_ok
);
    localparam int CW = $clog2(PWR_DLY + 1);
    logic [CW-1:0] ramp_cnt;

    // Count cycles of mismatch and flip power-good when the ramp completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_ok   <= 1'b0;
            ramp_cnt <= '0;
        end else if ((pwr_req != pwr_ok) && !hold) begin
            if (ramp_cnt == CW'(PWR_DLY - 1)) begin
                pwr_ok   <= pwr_req;
                ramp_cnt <= '0;
            end else begin
                ramp_cnt <= ramp_cnt + 1'b1;
            end
        end else begin
            ramp_cnt <= '0;
        end
    end
endmodule

// File: rtl/fuse_lock_bank.sv
// Sticky lock bank: one 32-bit register per group of word indices. A write
// ORs bits in, and only reset clears them. Assumes one-hot bank_we.
module fuse_lock_bank #(
    parameter int NBITS = 96,
    parameter int DW    = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [(NBITS+DW-1)/DW-1:0] bank_we,
    input  logic [DW-1:0]          wdata,
    output logic [((NBITS+DW-1)/DW)*DW-1:0] bits
);
    localparam int NBANK = (NBITS + DW - 1) / DW;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Set-only register for bank b.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bits[b*DW +: DW] <= '0;
            else if (bank_we[b])
                bits[b*DW +: DW] <= bits[b*DW +: DW] | wdata;
        end
    end
endmodule

// File: rtl/fuse_op_engine.sv
// Operation engine: accepts or rejects control writes, times the busy window
// and keeps the failure flag. fin marks the last busy cycle, in which the
// array access takes place. Assumes BUSY_CYC >= 1.
module fuse_op_engine
    import fuse_seq_pkg::*;
#(
    parameter int NWORDS   = 96,
    parameter int BUSY_CYC = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_we,
    input  fuse_op_e                  cmd_op,
    input  logic [CMD_IDX_W-1:0]      cmd_idx,
    input  logic                      pwr_ok,
    input  logic                      blocked_fail,
    output logic                      busy,
    output logic                      fin,
    output fuse_op_e                  op_kind,
    output logic [$clog2(NWORDS)-1:0] op_idx,
    output logic                      fail
);
    localparam int IDX_W = $clog2(NWORDS);
    localparam int CW    = $clog2(BUSY_CYC + 1);
    localparam logic [CMD_IDX_W-1:0] LAST_IDX = CMD_IDX_W'(NWORDS - 1);

    logic [CW-1:0] left_cnt;
    logic          accept;
    logic          reject;

    // Acceptance: powered, idle and index in range.
    always_comb begin
        accept = cmd_we && pwr_ok && !busy && (cmd_idx <= LAST_IDX);
        reject = cmd_we && !accept;
        fin    = busy && (left_cnt == '0);
    end

    // Busy window, latched operation and failure flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            left_cnt <= '0;
            op_kind  <= OP_SHADOW_LOAD;
            op_idx   <= '0;
            fail     <= 1'b0;
        end else if (accept) begin
            busy     <= 1'b1;
            left_cnt <= CW'(BUSY_CYC - 1);
            op_kind  <= cmd_op;
            op_idx   <= cmd_idx[IDX_W-1:0];
            fail     <= 1'b0;
        end else begin
            if (fin)
                busy <= 1'b0;
            else if (busy)
                left_cnt <= left_cnt - 1'b1;
            if (reject || (fin && blocked_fail))
                fail <= 1'b1;
        end
    end
endmodule

// File: rtl/fuse_seq.sv
// Fuse word sequencer top: register decode, sticky locks, shadow bank and
// array strobes. Assumes an external array with combinational read data
// that ORs arr_pgm_bits into the addressed word on a clock edge with
// arr_pgm_en high.
module fuse_seq
    import fuse_seq_pkg::*;
#(
    parameter int NWORDS   = 96,
    parameter int DW       = 32,
    parameter int ADDR_W   = 8,
    parameter int BUSY_CYC = 16,
    parameter int PWR_DLY  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_we,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DW-1:0]             bus_wdata,
    output logic [DW-1:0]             bus_rdata,
    output logic [$clog2(NWORDS)-1:0] arr_addr,
    output logic                      arr_rd_en,
    input  logic [DW-1:0]             arr_rdata,
    output logic                      arr_pgm_en,
    output logic [DW-1:0]             arr_pgm_bits
);
    localparam int IDX_W = $clog2(NWORDS);
    localparam int NBANK = (NWORDS + DW - 1) / DW;
    localparam logic [ADDR_W-1:0] SH_LO = ADDR_W'(A_SHADOW);
    localparam logic [ADDR_W-1:0] SH_HI = ADDR_W'(A_SHADOW + NWORDS);

    logic              pwr_req;
    logic              pwr_ok;
    logic [DW-1:0]     wdata_q;
    logic [DW-1:0]     glock_q;
    logic              glock_pgm;
    logic [NBANK-1:0]  plock_we;
    logic [NBANK-1:0]  rlock_we;
    logic [NBANK*DW-1:0] plock_bits;
    logic [NBANK*DW-1:0] rlock_bits;
    logic              busy;
    logic              fin;
    fuse_op_e          op_kind;
    logic [IDX_W-1:0]  op_idx;
    logic              fail;
    logic              cmd_we;
    logic              pgm_blocked;
    logic              blocked_fail;
    logic [DW-1:0]     shadow [NWORDS];

    assign cmd_we    = bus_we && (bus_addr == ADDR_W'(A_CMD));
    assign glock_pgm = glock_q[GLOCK_PGM_BIT];

    // Configuration, program data and global lock registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pwr_req <= 1'b0;
            wdata_q <= '0;
            glock_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == ADDR_W'(A_CFG))   pwr_req <= bus_wdata[CFG_PWR_BIT];
            if (bus_addr == ADDR_W'(A_WDATA)) wdata_q <= bus_wdata;
            if (bus_addr == ADDR_W'(A_GLOCK)) glock_q <= glock_q | bus_wdata;
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_lock_we
        assign plock_we[b] = bus_we && (bus_addr == ADDR_W'(A_PLOCK + b));
        assign rlock_we[b] = bus_we && (bus_addr == ADDR_W'(A_RLOCK + b));
    end

    fuse_lock_bank #(.NBITS(NWORDS), .DW(DW)) u_plock (
        .clk(clk), .rst_n(rst_n), .bank_we(plock_we),
        .wdata(bus_wdata), .bits(plock_bits)
    );

    fuse_lock_bank #(.NBITS(NWORDS), .DW(DW)) u_rlock (
        .clk(clk), .rst_n(rst_n), .bank_we(rlock_we),
        .wdata(bus_wdata), .bits(rlock_bits)
    );

    fuse_pwr_ctrl #(.PWR_DLY(PWR_DLY)) u_pwr (
        .clk(clk), .rst_n(rst_n), .pwr_req(pwr_req),
        .hold(busy), .pwr_ok(pwr_ok)
    );

    fuse_op_engine #(.NWORDS(NWORDS), .BUSY_CYC(BUSY_CYC)) u_eng (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we),
        .cmd_op(fuse_op_e'(bus_wdata[CMD_PGM_BIT])),
        .cmd_idx(bus_wdata[CMD_IDX_W-1:0]), .pwr_ok(pwr_ok),
        .blocked_fail(blocked_fail), .busy(busy), .fin(fin),
        .op_kind(op_kind), .op_idx(op_idx), .fail(fail)
    );

    // Lock resolution and array strobes for the last busy cycle.
    always_comb begin
        pgm_blocked  = plock_bits[op_idx] || glock_pgm;
        blocked_fail = (op_kind == OP_PROGRAM) && pgm_blocked && (wdata_q != '0);
        arr_addr     = op_idx;
        arr_pgm_bits = wdata_q;
        arr_pgm_en   = fin && (op_kind == OP_PROGRAM) && !pgm_blocked;
        arr_rd_en    = fin && (op_kind == OP_SHADOW_LOAD) && !rlock_bits[op_idx];
    end

    // Shadow bank: loaded only at the end of a shadow-load operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NWORDS; i++) shadow[i] <= '0;
        end else if (fin && (op_kind == OP_SHADOW_LOAD)) begin
            shadow[op_idx] <= rlock_bits[op_idx] ? '0 : arr_rdata;
        end
    end

    // Register read multiplexer.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(A_CFG))
            bus_rdata[CFG_PWR_BIT] = pwr_req;
        if (bus_addr == ADDR_W'(A_WDATA))
            bus_rdata = wdata_q;
        if (bus_addr == ADDR_W'(A_STAT)) begin
            bus_rdata[ST_BUSY_BIT] = busy;
            bus_rdata[ST_FAIL_BIT] = fail;
            bus_rdata[ST_PWR_BIT]  = pwr_ok;
        end
        if (bus_addr == ADDR_W'(A_GLOCK))
            bus_rdata = glock_q;
        for (int b = 0; b < NBANK; b++) begin
            if (bus_addr == ADDR_W'(A_PLOCK + b)) bus_rdata = plock_bits[b*DW +: DW];
            if (bus_addr == ADDR_W'(A_RLOCK + b)) bus_rdata = rlock_bits[b*DW +: DW];
        end
        if ((bus_addr >= SH_LO) && (bus_addr < SH_HI))
            bus_rdata = shadow[IDX_W'(bus_addr - SH_LO)];
    end
endmodule

// File: rtl/fuse_seq_chk.sv
// Checker for the fuse sequencer: timing and lock properties on the
// engine, power and array strobes. Bound into every fuse_seq instance.
module fuse_seq_chk #(
    parameter int NWORDS   = 96,
    parameter int BUSY_CYC = 16
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      busy,
    input logic                      pwr_req,
    input logic                      pwr_ok,
    input logic                      arr_rd_en,
    input logic                      arr_pgm_en,
    input logic [$clog2(NWORDS)-1:0] arr_addr,
    input logic                      glock_pgm
);
    localparam int CW = $clog2(BUSY_CYC + 2);
    logic [CW-1:0] busy_len;

    // Count the cycles busy has been high.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= '0;
        else if (busy) busy_len <= busy_len + 1'b1;
        else           busy_len <= '0;
    end

    p_busy_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == CW'(BUSY_CYC)));

    p_pwr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_req == pwr_ok) |=> $stable(pwr_ok));

    p_start_powered_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> pwr_ok);

    p_addr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en || arr_pgm_en) |-> (arr_addr < ($clog2(NWORDS))'(NWORDS)));

    p_glock_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        arr_pgm_en |-> !glock_pgm);

    p_pgm_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arr_pgm_en |=> !busy);

    p_one_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd_en, arr_pgm_en}));
endmodule

bind fuse_seq fuse_seq_chk #(.NWORDS(NWORDS), .BUSY_CYC(BUSY_CYC)) u_fuse_seq_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .pwr_req(pwr_req),
    .pwr_ok(pwr_ok), .arr_rd_en(arr_rd_en), .arr_pgm_en(arr_pgm_en),
    .arr_addr(arr_addr), .glock_pgm(glock_pgm)
);

// File: tb/test_fuse_seq.sv
`timescale 1ns/1ps
module test_fuse_seq;
    localparam int NW = 96;
    localparam int BC = 16;
    localparam int PD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [6:0]  arr_addr;
    logic        arr_rd_en;
    logic [31:0] arr_rdata;
    logic        arr_pgm_en;
    logic [31:0] arr_pgm_bits;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] fmem [NW];
    logic [31:0] ref_mem [NW];
    logic [31:0] sh_exp [NW];
    bit          plk [NW];
    bit          rlk [NW];
    bit          glk = 1'b0;

    // Stimulus vectors: {program, index, data}.
    localparam logic [40:0] VEC [8] = '{
        {1'b0, 8'd0,  32'h0000_0000},
        {1'b0, 8'd95, 32'h0000_0000},
        {1'b1, 8'd5,  32'h0000_00F0},
        {1'b0, 8'd5,  32'h0000_0000},
        {1'b1, 8'd5,  32'h0F00_0000},
        {1'b0, 8'd5,  32'h0000_0000},
        {1'b1, 8'd95, 32'h8000_0001},
        {1'b0, 8'd95, 32'h0000_0000}
    };

    always #4 clk = ~clk;

    fuse_seq i_fuse_seq (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .arr_addr(arr_addr),
        .arr_rd_en(arr_rd_en), .arr_rdata(arr_rdata), .arr_pgm_en(arr_pgm_en),
        .arr_pgm_bits(arr_pgm_bits)
    );

    function automatic logic [31:0] seed_word(input int i);
        return (32'(i) * 32'h0001_0F03) ^ 32'h3C00_0000;
    endfunction

    // Behavioural fuse array: bits can only be set.
    initial for (int i = 0; i < NW; i++) fmem[i] = seed_word(i);
    assign arr_rdata = (int'(arr_addr) < NW) ? fmem[arr_addr] : 32'h0;
    always @(posedge clk) if (arr_pgm_en) fmem[arr_addr] <= fmem[arr_addr] | arr_pgm_bits;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Run one accepted operation and check busy window, fail flag and shadow.
    task automatic run_op(input bit pgm, input int idx, input logic [31:0] wd);
        logic [31:0] v;
        bit locked, exp_fail;
        locked   = plk[idx] || glk;
        exp_fail = pgm && locked && (wd != 0);
        wr(8'h02, wd);
        wr(8'h01, {23'd0, pgm, 8'(idx)});
        rd(8'h03, v);
        chk(v[3] == 1'b1, "R3 busy after start", v, 32'h8);
        repeat (BC - 1) @(negedge clk);
        rd(8'h03, v);
        chk(v[3] == 1'b1, "R3 busy in last cycle", v, 32'h8);
        @(negedge clk);
        rd(8'h03, v);
        chk(v[3] == 1'b0, "R3 busy cleared", v, 32'h0);
        chk(v[4] == exp_fail, pgm ? "R6 R7 R8 R12 fail flag" : "R12 fail flag", v, {27'd0, exp_fail, 4'd0});
        if (pgm) begin
            if (!locked) ref_mem[idx] = ref_mem[idx] | wd;
            chk(fmem[idx] == ref_mem[idx], "R6 R7 R8 array word", fmem[idx], ref_mem[idx]);
        end else begin
            sh_exp[idx] = rlk[idx] ? 32'h0 : ref_mem[idx];
        end
        rd(8'(8'h80 + idx), v);
        chk(v == sh_exp[idx], pgm ? "R6 shadow unchanged" : "R4 R5 shadow load", v, sh_exp[idx]);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < NW; i++) begin
            ref_mem[i] = seed_word(i); sh_exp[i] = 0; plk[i] = 0; rlk[i] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state.
        rd(8'h03, v); chk(v == 0, "R1 status", v, 0);
        rd(8'h00, v); chk(v == 0, "R1 config", v, 0);
        rd(8'h08, v); chk(v == 0, "R1 lock bank", v, 0);
        rd(8'hDF, v); chk(v == 0, "R1 shadow 95", v, 0);

        // R9: command while unpowered.
        wr(8'h01, 32'd3);
        rd(8'h03, v); chk(v[3] == 0 && v[4] == 1, "R9 unpowered reject", v, 32'h10);
        rd(8'h83, v); chk(v == 0, "R9 shadow untouched", v, 0);

        // R2: power-up ramp.
        wr(8'h00, 32'h1);
        repeat (PD - 1) @(negedge clk);
        rd(8'h03, v); chk(v[5] == 0, "R2 power not yet good", v, 0);
        @(negedge clk);
        rd(8'h03, v); chk(v[5] == 1, "R2 power good", v, 32'h20);

        // Vector table.
        for (int k = 0; k < 8; k++) run_op(VEC[k][40], int'(VEC[k][39:32]), VEC[k][31:0]);

        // R9: command while busy.
        wr(8'h01, 32'd2);
        repeat (3) @(negedge clk);
        wr(8'h01, 32'd40);
        rd(8'h03, v); chk(v[3] == 1 && v[4] == 1, "R9 busy reject", v, 32'h18);
        repeat (40) @(negedge clk);
        sh_exp[2] = ref_mem[2];
        rd(8'h03, v); chk(v[3] == 0 && v[4] == 1, "R9 first op completes", v, 32'h10);
        rd(8'h82, v); chk(v == sh_exp[2], "R9 first op shadow", v, sh_exp[2]);
        rd(8'hA8, v); chk(v == 0, "R9 second op dropped", v, 0);

        // R12: next accepted command clears the failure flag.
        run_op(1'b0, 1, 32'h0);

        // R10: index out of range.
        wr(8'h01, 32'd96);
        rd(8'h03, v); chk(v[3] == 0 && v[4] == 1, "R10 index 96 reject", v, 32'h10);

        // R7: per-word program lock on word 7 (bank 0, bit 7).
        wr(8'h08, 32'h80); plk[7] = 1;
        run_op(1'b1, 7, 32'hFFFF_FFFF);
        run_op(1'b0, 7, 32'h0);

        // R11: locks are sticky.
        wr(8'h08, 32'h0);
        rd(8'h08, v); chk(v == 32'h80, "R11 sticky lock", v, 32'h80);

        // R5: shadow-read lock on word 32 (bank 1, bit 0).
        run_op(1'b0, 32, 32'h0);
        wr(8'h0D, 32'h1); rlk[32] = 1;
        run_op(1'b0, 32, 32'h0);

        // R8: global program lock.
        wr(8'h04, 32'h10); glk = 1;
        run_op(1'b1, 9, 32'h0000_0001);
        run_op(1'b1, 10, 32'h0);

        // R2: power-down ramp.
        wr(8'h00, 32'h0);
        repeat (PD - 1) @(negedge clk);
        rd(8'h03, v); chk(v[5] == 1, "R2 power still good", v, 32'h20);
        @(negedge clk);
        rd(8'h03, v); chk(v[5] == 0, "R2 power off", v, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule